// File: doc/BRIEF.md
# Four-Channel Double-Buffered Converter Register Front End

This block sits between a parallel host bus and a four-channel voltage-output converter. The host picks a channel with a two-bit address and presents a code and a range bit. It pulls the active-low select low and produces a low-then-high pulse on the active-low write strobe. On the strobe's return to high, the code lands in that channel's first-rank (staging) register. The analog side does not see it yet.

A separate active-low load strobe copies every staging register, code and range bit together, into the second rank that drives the converter. All four outputs therefore change on the same clock edge. An active-low clear empties both ranks at once, without waiting for a clock. A power-down request is registered and passed to the analog side as a flag.

A build-time option selects byte-split loading. In that mode each write fills either the low eight bits or the top bits of the staging code, chosen by a byte-steer input. The strobes are sampled by the block clock. Each one must stay at a level for at least one clock period, so the bus interface is a plain strobe interface with no back-pressure. The block always accepts a write in the cycle it is detected.

Top module: `dacif_quad_front`

## Requirements
- R1: After `rst_n` is released, every output code, every range bit and `pwr_down_o` read zero.
- R2: A write is detected on the first clock edge at which `wr_n` is sampled high after it was sampled low, with `cs_n` low in that same sample. It updates only the staging register of channel `ch_addr` (0 to 3 select channels 0 to 3). `dac_code_o` and `dac_gain_o` keep their values while `ldac_n` stays high.
- R3: A `wr_n` pulse with `cs_n` sampled high at its rising sample changes no staging register. A later load shows the previous contents.
- R4: Each clock edge at which `ldac_n` is sampled low copies all four staging registers into the output rank. Channel k's code appears on `dac_code_o[k*CODE_W +: CODE_W]` after that edge.
- R5: If `ldac_n` is low on the edge that detects a write, the newly written value appears on that channel's output after that same edge.
- R6: While `clr_n` is low, both ranks are zero. The outputs drop to zero without a clock edge. Writes and loads attempted during the clear leave nothing behind.
- R7: The `gain_sel` value at a write is stored with that channel's code. It appears on `dac_gain_o[k]` after a load (0 = one times the reference, 1 = two times).
- R8: With `SPLIT_LOAD = 0`, a write stores all `CODE_W` bits of `wr_data`, with bit `CODE_W-1` as the MSB, and `hi_byte_en` has no effect.
- R9: With `SPLIT_LOAD = 1`, a write with `hi_byte_en = 0` replaces code bits [7:0] with `wr_data[7:0]`. A write with `hi_byte_en = 1` replaces the upper `CODE_W-8` bits with `wr_data[CODE_W-9:0]`. The other part of the code is kept.
- R10: `pwr_down_o` equals the inverse of `pd_n` as sampled on the previous clock edge. It is unaffected by `clr_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples all strobes |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| clr_n | input | 1 | Active-low asynchronous clear of both register ranks |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; the write happens on its return to high |
| ldac_n | input | 1 | Active-low load strobe, level sensitive |
| ch_addr | input | 2 | Target channel of a write |
| wr_data | input | 10 | Code word (low bits only in byte-split mode) |
| gain_sel | input | 1 | Range bit stored with the written code |
| hi_byte_en | input | 1 | Byte steer in byte-split mode |
| pd_n | input | 1 | Active-low power-down request |
| dac_code_o | output | 40 | Output-rank codes, channel k at bits [k*10 +: 10] |
| dac_gain_o | output | 4 | Output-rank range bits, one per channel |
| pwr_down_o | output | 1 | Registered power-down flag |

## Verification
The assertions assume that `clr_n` does not pulse low and back high between two clock edges. They also assume every strobe level lasts at least one clock. The stimulus changes inputs only on the falling clock edge and holds each strobe level for one full period or more. The load checks treat a cycle with `cs_n` sampled high as free of writes. The stimulus therefore raises `wr_n` only while `cs_n` is held, except in the deliberate ignored-write case.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  // Which part of a staging code a detected write replaces.
  typedef enum logic [1:0] {
    LANE_NONE = 2'd0,
    LANE_FULL = 2'd1,
    LANE_LOW  = 2'd2,
    LANE_HIGH = 2'd3
  } lane_e;

  localparam int unsigned DEF_CHANNELS = 4;
  localparam int unsigned DEF_CODE_W   = 10;
  localparam int unsigned DEF_LOW_W    = 8;
endpackage

// File: rtl/dacif_strobe.sv
module dacif_strobe
  import dacif_pkg::*;
#(
  parameter bit SPLIT_LOAD = 1'b0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cs_n,
  input  logic  wr_n,
  input  logic  hi_byte_en,
  output logic  wr_evt,
  output lane_e lane
);
  logic wr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev <= 1'b1;
    else        wr_prev <= wr_n;
  end

  // Rising return of the strobe while the chip is selected.
  assign wr_evt = !cs_n && wr_n && !wr_prev;

  generate
    if (SPLIT_LOAD) begin : g_split
      always_comb begin
        if (!wr_evt)         lane = LANE_NONE;
        else if (hi_byte_en) lane = LANE_HIGH;
        else                 lane = LANE_LOW;
      end
    end else begin : g_word
      always_comb lane = wr_evt ? LANE_FULL : LANE_NONE;
    end
  endgenerate
endmodule

// File: rtl/dacif_input_rank.sv
module dacif_input_rank
  import dacif_pkg::*;
#(
  parameter int unsigned CHANNELS = DEF_CHANNELS,
  parameter int unsigned CODE_W   = DEF_CODE_W,
  parameter int unsigned LOW_W    = DEF_LOW_W,
  localparam int unsigned ADDR_W  = $clog2(CHANNELS),
  localparam int unsigned HI_W    = CODE_W - LOW_W
) (
  input  logic                       clk,
  input  logic                       kill_n,
  input  lane_e                      lane,
  input  logic [ADDR_W-1:0]          ch_addr,
  input  logic [CODE_W-1:0]          wr_data,
  input  logic                       gain_sel,
  output logic [CHANNELS*CODE_W-1:0] stage_code,
  output logic [CHANNELS-1:0]        stage_gain,
  output logic [CHANNELS*CODE_W-1:0] stage_code_nxt,
  output logic [CHANNELS-1:0]        stage_gain_nxt
);
  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    logic [CODE_W-1:0] cur, nxt;
    logic              g_cur, g_nxt;
    logic              hit;

    assign hit = (lane != LANE_NONE) && (ch_addr == ADDR_W'(k));

    always_comb begin
      nxt   = cur;
      g_nxt = g_cur;
      if (hit) begin
        g_nxt = gain_sel;
        unique case (lane)
          LANE_FULL: nxt = wr_data;
          LANE_LOW:  nxt[LOW_W-1:0] = wr_data[LOW_W-1:0];
          LANE_HIGH: nxt[CODE_W-1:LOW_W] = wr_data[HI_W-1:0];
          default:   nxt = cur;
        endcase
      end
    end

    always_ff @(posedge clk or negedge kill_n) begin
      if (!kill_n) begin
        cur   <= '0;
        g_cur <= 1'b0;
      end else begin
        cur   <= nxt;
        g_cur <= g_nxt;
      end
    end

    assign stage_code[k*CODE_W +: CODE_W]     = cur;
    assign stage_gain[k]                      = g_cur;
    assign stage_code_nxt[k*CODE_W +: CODE_W] = nxt;
    assign stage_gain_nxt[k]                  = g_nxt;
  end
endmodule

// File: rtl/dacif_output_rank.sv
module dacif_output_rank #(
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned CODE_W   = 10
) (
  input  logic                       clk,
  input  logic                       kill_n,
  input  logic                       ldac_n,
  input  logic [CHANNELS*CODE_W-1:0] src_code,
  input  logic [CHANNELS-1:0]        src_gain,
  output logic [CHANNELS*CODE_W-1:0] out_code,
  output logic [CHANNELS-1:0]        out_gain
);
  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    always_ff @(posedge clk or negedge kill_n) begin
      if (!kill_n) begin
        out_code[k*CODE_W +: CODE_W] <= '0;
        out_gain[k]                  <= 1'b0;
      end else if (!ldac_n) begin
        out_code[k*CODE_W +: CODE_W] <= src_code[k*CODE_W +: CODE_W];
        out_gain[k]                  <= src_gain[k];
      end
    end
  end
endmodule

// File: rtl/dacif_quad_front.sv
module dacif_quad_front
  import dacif_pkg::*;
#(
  parameter int unsigned CHANNELS   = DEF_CHANNELS,
  parameter int unsigned CODE_W     = DEF_CODE_W,
  parameter int unsigned LOW_W      = DEF_LOW_W,
  parameter bit          SPLIT_LOAD = 1'b0,
  localparam int unsigned ADDR_W    = $clog2(CHANNELS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_n,
  input  logic                       cs_n,
  input  logic                       wr_n,
  input  logic                       ldac_n,
  input  logic [ADDR_W-1:0]          ch_addr,
  input  logic [CODE_W-1:0]          wr_data,
  input  logic                       gain_sel,
  input  logic                       hi_byte_en,
  input  logic                       pd_n,
  output logic [CHANNELS*CODE_W-1:0] dac_code_o,
  output logic [CHANNELS-1:0]        dac_gain_o,
  output logic                       pwr_down_o
);
  logic                       kill_n;
  logic                       wr_evt;
  lane_e                      lane;
  logic [CHANNELS*CODE_W-1:0] in_code_w, in_code_nxt;
  logic [CHANNELS-1:0]        in_gain_w, in_gain_nxt;

  // Either reset source empties both ranks at once.
  assign kill_n = rst_n & clr_n;

  dacif_strobe #(.SPLIT_LOAD(SPLIT_LOAD)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
    .hi_byte_en(hi_byte_en), .wr_evt(wr_evt), .lane(lane)
  );

  dacif_input_rank #(.CHANNELS(CHANNELS), .CODE_W(CODE_W), .LOW_W(LOW_W)) u_stage (
    .clk(clk), .kill_n(kill_n), .lane(lane), .ch_addr(ch_addr),
    .wr_data(wr_data), .gain_sel(gain_sel),
    .stage_code(in_code_w), .stage_gain(in_gain_w),
    .stage_code_nxt(in_code_nxt), .stage_gain_nxt(in_gain_nxt)
  );

  // The output rank takes the staging next-state, so a write during a load passes straight through.
  dacif_output_rank #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_out (
    .clk(clk), .kill_n(kill_n), .ldac_n(ldac_n),
    .src_code(in_code_nxt), .src_gain(in_gain_nxt),
    .out_code(dac_code_o), .out_gain(dac_gain_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_down_o <= 1'b0;
    else        pwr_down_o <= !pd_n;
  end
endmodule

// File: rtl/dacif_quad_front_chk.sv
module dacif_quad_front_chk #(
  parameter int unsigned CHANNELS = 4,
  parameter int unsigned CODE_W   = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       clr_n,
  input logic                       cs_n,
  input logic                       ldac_n,
  input logic                       pd_n,
  input logic [CHANNELS*CODE_W-1:0] code_o,
  input logic [CHANNELS-1:0]        gain_o,
  input logic                       pwr_down_o,
  input logic [CHANNELS*CODE_W-1:0] in_code
);
  p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (code_o == '0 && gain_o == '0));

  p_hold_without_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_n && clr_n) |=> ($stable(code_o) || !clr_n));

  p_load_copies_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ldac_n && clr_n && cs_n) |=> (code_o == $past(in_code) || !clr_n));

  p_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && clr_n) |=> ($stable(in_code) || !clr_n));

  p_pd_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pwr_down_o == !$past(pd_n)));
endmodule

bind dacif_quad_front dacif_quad_front_chk #(.CHANNELS(CHANNELS), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .ldac_n(ldac_n),
  .pd_n(pd_n), .code_o(dac_code_o), .gain_o(dac_gain_o),
  .pwr_down_o(pwr_down_o), .in_code(in_code_w)
);

// File: tb/dacif_quad_front_test.sv
`timescale 1ns/1ps
module dacif_quad_front_test;
  localparam int NCH = 4;
  localparam int CW  = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, clr_n = 1'b1, cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1;
  logic [1:0] ch_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic gain_sel = 1'b0, hi_byte_en = 1'b0, pd_n = 1'b1;
  logic [NCH*CW-1:0] code_w, code_b;
  logic [NCH-1:0] gain_w, gain_b;
  logic pd_w, pd_b;

  dacif_quad_front uut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .ldac_n(ldac_n), .ch_addr(ch_addr), .wr_data(wr_data), .gain_sel(gain_sel),
    .hi_byte_en(hi_byte_en), .pd_n(pd_n),
    .dac_code_o(code_w), .dac_gain_o(gain_w), .pwr_down_o(pd_w)
  );

  dacif_quad_front #(.SPLIT_LOAD(1'b1)) uut_byte (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .cs_n(cs_n), .wr_n(wr_n),
    .ldac_n(ldac_n), .ch_addr(ch_addr), .wr_data(wr_data), .gain_sel(gain_sel),
    .hi_byte_en(hi_byte_en), .pd_n(pd_n),
    .dac_code_o(code_b), .dac_gain_o(gain_b), .pwr_down_o(pd_b)
  );

  // {channel, range bit, code}
  localparam logic [12:0] VEC [8] = '{
    {2'd0, 1'b1, 10'h3FF}, {2'd1, 1'b0, 10'h155},
    {2'd2, 1'b1, 10'h2AA}, {2'd3, 1'b0, 10'h001},
    {2'd0, 1'b0, 10'h000}, {2'd3, 1'b1, 10'h200},
    {2'd1, 1'b1, 10'h0F0}, {2'd1, 1'b0, 10'h30C}
  };

  int checks = 0, errors = 0;
  logic [CW-1:0] exp_in [NCH];
  logic [CW-1:0] exp_out [NCH];
  logic          exp_gin [NCH];
  logic          exp_gout [NCH];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NCH*CW-1:0] pack_code();
    logic [NCH*CW-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*CW +: CW] = exp_out[k];
    return v;
  endfunction

  function automatic logic [NCH-1:0] pack_gain();
    logic [NCH-1:0] v;
    for (int k = 0; k < NCH; k++) v[k] = exp_gout[k];
    return v;
  endfunction

  task automatic do_write(input logic [1:0] a, input logic [CW-1:0] d, input logic g,
                          input logic hb, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n; ch_addr = a; wr_data = d; gain_sel = g; hi_byte_en = hb; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic do_load();
    @(negedge clk);
    ldac_n = 1'b0;
    @(negedge clk);
    ldac_n = 1'b1;
    for (int k = 0; k < NCH; k++) begin
      exp_out[k] = exp_in[k];
      exp_gout[k] = exp_gin[k];
    end
  endtask

  task automatic zero_model();
    for (int k = 0; k < NCH; k++) begin
      exp_in[k] = '0; exp_out[k] = '0; exp_gin[k] = 1'b0; exp_gout[k] = 1'b0;
    end
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    zero_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 code", 64'(code_w), 64'(0));
    chk("R1 gain", 64'(gain_w), 64'(0));
    chk("R1 pd", 64'(pd_w), 64'(0));

    // Table walk: R2 staging only, R4 load, R7 range bit
    for (int i = 0; i < 8; i++) begin
      do_write(VEC[i][12:11], VEC[i][9:0], VEC[i][10], 1'b0, 1'b0);
      exp_in[VEC[i][12:11]] = VEC[i][9:0];
      exp_gin[VEC[i][12:11]] = VEC[i][10];
      chk("R2 output held after write", 64'(code_w), 64'(pack_code()));
      if (i % 4 == 3) begin
        do_load();
        chk("R4 codes after load", 64'(code_w), 64'(pack_code()));
        chk("R7 range bits after load", 64'(gain_w), 64'(pack_gain()));
      end
    end

    // R3: deselected write ignored
    do_write(2'd2, 10'h111, 1'b0, 1'b0, 1'b1);
    do_load();
    chk("R3 deselected write", 64'(code_w), 64'(pack_code()));

    // R5: write while load held passes through
    @(negedge clk);
    ldac_n = 1'b0;
    do_write(2'd0, 10'h0AB, 1'b1, 1'b0, 1'b0);
    chk("R5 pass-through ch0", 64'(code_w[CW-1:0]), 64'(10'h0AB));
    chk("R5 pass-through range", 64'(gain_w[0]), 64'(1));
    ldac_n = 1'b1;

    // R6: asynchronous clear, overriding write and load
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    chk("R6 clear without clock", 64'(code_w), 64'(0));
    chk("R6 clear range bits", 64'(gain_w), 64'(0));
    ldac_n = 1'b0;
    do_write(2'd3, 10'h3C3, 1'b1, 1'b0, 1'b0);
    ldac_n = 1'b1;
    chk("R6 held during write", 64'(code_w), 64'(0));
    @(negedge clk);
    clr_n = 1'b1;
    zero_model();
    do_load();
    chk("R6 staging empty after clear", 64'(code_w), 64'(0));
    chk("R6 byte instance empty", 64'(code_b), 64'(0));

    // R8 (word instance) and R9 (byte instance)
    do_write(2'd1, 10'h0A5, 1'b0, 1'b0, 1'b0);
    do_write(2'd1, 10'h003, 1'b0, 1'b1, 1'b0);
    do_load();
    chk("R8 hi_byte_en ignored", 64'(code_w[CW +: CW]), 64'(10'h003));
    chk("R9 low then high byte", 64'(code_b[CW +: CW]), 64'(10'h3A5));
    do_write(2'd1, 10'h1FF, 1'b0, 1'b0, 1'b0);
    do_load();
    chk("R9 low byte keeps upper", 64'(code_b[CW +: CW]), 64'(10'h3FF));
    chk("R8 full word", 64'(code_w[CW +: CW]), 64'(10'h1FF));

    // R10: power-down flag
    @(negedge clk);
    pd_n = 1'b0;
    @(negedge clk);
    chk("R10 flag set", 64'(pd_w), 64'(1));
    clr_n = 1'b0;
    @(negedge clk);
    chk("R10 flag during clear", 64'(pd_w), 64'(1));
    clr_n = 1'b1;
    pd_n = 1'b1;
    @(negedge clk);
    chk("R10 flag cleared", 64'(pd_w), 64'(0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule